// File: doc/BRIEF.md
# Ethernet Transmit Frame Sequencer

The sequencer takes one outgoing frame at a time as a byte stream and sends it bit by bit on a serial line, with a transmit-enable strobe. Each byte goes out least-significant bit first. When a frame's pad flag is set, the sequencer adds zero bytes until the frame reaches a programmed minimum length. When the frame's check flag is set, it then sends a four-byte CRC-32 frame check sequence. The pad and check flags are sampled with the first byte of the frame. At the end of every frame, and at every abort, the sequencer raises a one-cycle status pulse.

The first `DEPTH` bytes taken from upstream are kept in a local replay store. A collision seen while those are the only bytes consumed drops transmit enable and enters backoff. When the backoff-expired pulse arrives, the frame is resent from its first byte without asking upstream for anything again. A collision after more than `DEPTH` bytes were consumed is a late collision and aborts the frame. The `MAX_ATT`-th collision aborts the frame as excessive. After either abort, the unread rest of the frame is drained from upstream.

A stop command halts the sequencer at once when no frame is in progress. During a frame, the stop takes effect only after that frame completes or after it collides. A restart command leaves the halted state. The sequencer has five states:

- **S_IDLE**: waits for a first byte. It goes to S_XMIT when a byte is presented, or to S_HALT when a stop is pending.
- **S_XMIT**: shifts bytes out. On finish it goes to S_IDLE or S_HALT. On a collision it goes to S_BACKOFF, S_HALT (stop pending), S_DRAIN (abort with bytes left) or S_IDLE/S_HALT (abort with the frame fully read).
- **S_BACKOFF**: waits for the backoff pulse, then goes to S_XMIT.
- **S_DRAIN**: accepts and discards bytes up to the last one, then goes to S_IDLE or S_HALT.
- **S_HALT**: on restart, goes to S_BACKOFF if a collided frame is held, otherwise to S_IDLE.

Top module: `eth_tx_seq`

## Requirements
- R1: Each byte is sent least-significant bit first, one bit per clock on `tx_d`, while `tx_en` is high. `tx_d` is 0 whenever `tx_en` is low.
- R2: A byte is consumed only on a cycle with `in_valid` and `in_ready` both high, and each frame byte is consumed exactly once even across collision retries.
- R3: With the pad flag set, zero bytes (0x00) follow the data until data plus pad equals `min_len`. No pad is added when the data is already at least `min_len` bytes or the flag is clear.
- R4: With the check flag set, four bytes follow the data and pad: the complement of the reflected CRC-32 (polynomial 0x04C11DB7, preset all ones) over data and pad, lowest-order byte first. With the flag clear, nothing follows.
- R5: A collision while sending drops `tx_en` on the next cycle. Transmission resumes only after `backoff_done`, and the line then carries the whole frame again from its first byte.
- R6: A collision after more than `DEPTH` bytes were consumed ends the frame with `st_late` set, sends nothing more of it, and drains its remaining bytes.
- R7: The `MAX_ATT`-th collision of one frame ends it with `st_excess` set and `st_retries` equal to `MAX_ATT`. `st_late` and `st_excess` are never set together.
- R8: A frame with fewer than `MIN_SEG` data bytes is still sent, and its status has `st_short` set. Longer frames have `st_short` clear.
- R9: A stop command while idle sets `stopped` on the next cycle. While `stopped` is high, `in_ready` and `tx_en` stay low.
- R10: A stop command during a frame lets that frame complete intact, and `stopped` rises in the same cycle as its `done` pulse.
- R11: A restart command while halted clears `stopped` on the next cycle. A restart command while not halted has no effect on `stopped`.
- R12: `done` is a single-cycle pulse per frame. `st_retries` carries the number of collisions the frame met.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Upstream byte present |
| in_ready | output | 1 | Byte accepted this cycle when valid |
| in_data | input | 8 | Upstream byte |
| in_last | input | 1 | Byte is the last of the frame |
| in_pad | input | 1 | Pad flag, sampled with the first byte |
| in_fcs | input | 1 | Check-sequence flag, sampled with the first byte |
| min_len | input | LEN_W | Minimum length in bytes for padding |
| col | input | 1 | Collision seen on the line |
| backoff_done | input | 1 | Backoff interval expired pulse |
| stop_req | input | 1 | Graceful stop command pulse |
| restart_req | input | 1 | Restart command pulse |
| tx_en | output | 1 | Transmit enable |
| tx_d | output | 1 | Serial data |
| stopped | output | 1 | Sequencer halted |
| done | output | 1 | Frame end / abort pulse |
| st_retries | output | RW | Collisions met by the frame |
| st_late | output | 1 | Late-collision abort |
| st_excess | output | 1 | Excessive-collision abort |
| st_short | output | 1 | Frame had fewer than MIN_SEG data bytes |

## Verification
A wrong byte index or fetch count shows on the serial line within one byte time (8 cycles) as a shifted, repeated or missing byte. A retry that rereads upstream instead of the replay store shows up the same way, as a frame that differs from the one offered. A corrupted CRC register only appears in the final four bytes. Any error in the collision counter or the spill test becomes visible in the status word of the `done` pulse, which is registered one cycle after the deciding edge. A stop flag that is lost or sticks shows in `stopped` or in a hung or unexpected `in_ready` within a cycle of the frame boundary.

// File: rtl/eth_tx_pkg.sv
package eth_tx_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_XMIT,
        S_BACKOFF,
        S_DRAIN,
        S_HALT
    } tx_state_e;

    localparam logic [31:0] CRC_REFL_POLY = 32'hEDB8_8320;

    // one byte through the reflected CRC-32, bit 0 of the byte first
    function automatic logic [31:0] crc32_step(input logic [31:0] c, input logic [7:0] d);
        logic [31:0] r;
        r = c;
        for (int i = 0; i < 8; i++) begin
            r = (r >> 1) ^ ((r[0] ^ d[i]) ? CRC_REFL_POLY : 32'h0);
        end
        return r;
    endfunction

endpackage

// File: rtl/eth_tx_replay.sv
module eth_tx_replay #(
    parameter int DEPTH = 8,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/eth_tx_fcs.sv
module eth_tx_fcs
    import eth_tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       init,
    input  logic       upd,
    input  logic [7:0] din,
    input  logic [1:0] sel,
    output logic [7:0] fcs_byte
);
    logic [31:0] crc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    crc <= '1;
        else if (init) crc <= '1;
        else if (upd)  crc <= crc32_step(crc, din);
    end

    assign fcs_byte = ~crc[8*sel +: 8];
endmodule

// File: rtl/eth_tx_seq.sv
module eth_tx_seq
    import eth_tx_pkg::*;
#(
    parameter int LEN_W   = 11,
    parameter int DEPTH   = 8,
    parameter int MIN_SEG = 9,
    parameter int MAX_ATT = 16,
    localparam int RW = $clog2(MAX_ATT + 1),
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [7:0]       in_data,
    input  logic             in_last,
    input  logic             in_pad,
    input  logic             in_fcs,
    input  logic [LEN_W-1:0] min_len,
    input  logic             col,
    input  logic             backoff_done,
    input  logic             stop_req,
    input  logic             restart_req,
    output logic             tx_en,
    output logic             tx_d,
    output logic             stopped,
    output logic             done,
    output logic [RW-1:0]    st_retries,
    output logic             st_late,
    output logic             st_excess,
    output logic             st_short
);
    tx_state_e        state, state_nx;
    logic             has;
    logic [2:0]       bcnt;
    logic [7:0]       shreg;
    logic [LEN_W-1:0] idx, fetched, data_len, fetch_nx;
    logic             ended, pad_f, fcs_f, stop_pend, resume;
    logic [2:0]       fcs_cnt;
    logic [RW-1:0]    attempts, att_nx;
    logic [7:0]       rd_byte, fcs_byte, nb;

    logic at_bnd, from_buf, data_rem, pad_rem, fcs_rem;
    logic col_hit, take, load, finish, spilled, give_up, abort;
    logic start, stop_any, ended_nx;
    tx_state_e end_st;

    // ---------------- control decode ----------------
    always_comb begin
        at_bnd   = (state == S_XMIT) && (!has || bcnt == 3'd7);
        from_buf = idx < fetched;
        data_rem = from_buf || !ended;
        pad_rem  = pad_f && (idx < min_len);
        fcs_rem  = fcs_f && (fcs_cnt != 3'd4);
        col_hit  = (state == S_XMIT) && col;
        in_ready = (at_bnd && data_rem && !from_buf) || (state == S_DRAIN);
        take     = in_ready && in_valid;
        fetch_nx = fetched + LEN_W'(take && state == S_XMIT);
        spilled  = fetch_nx > LEN_W'(DEPTH);
        att_nx   = attempts + 1'b1;
        give_up  = spilled || (att_nx == RW'(MAX_ATT));
        abort    = col_hit && give_up;
        ended_nx = ended || (take && in_last);
        load     = at_bnd && !col &&
                   (data_rem ? (from_buf || in_valid) : (pad_rem || fcs_rem));
        finish   = at_bnd && !col && !data_rem && !pad_rem && !fcs_rem;
        nb       = data_rem ? (from_buf ? rd_byte : in_data)
                            : (pad_rem ? 8'h00 : fcs_byte);
        stop_any = stop_pend || stop_req;
        end_st   = stop_any ? S_HALT : S_IDLE;
        start    = (state == S_IDLE) && !stop_any && in_valid;
    end

    // ---------------- next state ----------------
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:    if (stop_any) state_nx = S_HALT;
                       else if (in_valid) state_nx = S_XMIT;
            S_XMIT:    if (col_hit) begin
                           if (give_up)       state_nx = ended_nx ? end_st : S_DRAIN;
                           else if (stop_any) state_nx = S_HALT;
                           else               state_nx = S_BACKOFF;
                       end else if (finish) state_nx = end_st;
            S_BACKOFF: if (backoff_done) state_nx = S_XMIT;
            S_DRAIN:   if (take && in_last) state_nx = end_st;
            S_HALT:    if (restart_req) state_nx = resume ? S_BACKOFF : S_IDLE;
            default:   state_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // ---------------- frame datapath ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            has <= 1'b0;  bcnt <= '0;  shreg <= '0;
            idx <= '0;  fetched <= '0;  data_len <= '0;
            ended <= 1'b0;  pad_f <= 1'b0;  fcs_f <= 1'b0;
            fcs_cnt <= '0;  attempts <= '0;
            stop_pend <= 1'b0;  resume <= 1'b0;
        end else begin
            stop_pend <= stop_any && (state_nx != S_HALT) && (state != S_HALT);
            if (col_hit && !give_up && stop_any)         resume <= 1'b1;
            else if (state == S_HALT && restart_req)     resume <= 1'b0;
            if (start) begin
                pad_f <= in_pad;  fcs_f <= in_fcs;
                idx <= '0;  fetched <= '0;  data_len <= '0;
                ended <= 1'b0;  fcs_cnt <= '0;  attempts <= '0;  has <= 1'b0;
            end else if (state == S_XMIT) begin
                if (take) begin
                    fetched <= fetch_nx;
                    if (in_last) begin
                        ended    <= 1'b1;
                        data_len <= fetch_nx;
                    end
                end
                if (col) begin
                    has <= 1'b0;  idx <= '0;  fcs_cnt <= '0;  attempts <= att_nx;
                end else if (load) begin
                    shreg <= nb;  has <= 1'b1;  bcnt <= '0;
                    if (data_rem || pad_rem) idx <= idx + 1'b1;
                    else                     fcs_cnt <= fcs_cnt + 1'b1;
                end else if (has) begin
                    shreg <= shreg >> 1;
                    bcnt  <= bcnt + 1'b1;
                    if (bcnt == 3'd7) has <= 1'b0;
                end
            end
        end
    end

    // ---------------- status pulse ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done <= 1'b0;  st_retries <= '0;
            st_late <= 1'b0;  st_excess <= 1'b0;  st_short <= 1'b0;
        end else begin
            done       <= finish || abort;
            st_retries <= finish ? attempts : att_nx;
            st_late    <= abort && spilled;
            st_excess  <= abort && !spilled;
            st_short   <= finish && (data_len < LEN_W'(MIN_SEG));
        end
    end

    // ---------------- line outputs ----------------
    always_comb begin
        tx_en   = (state == S_XMIT) && has;
        tx_d    = tx_en && shreg[0];
        stopped = (state == S_HALT);
    end

    eth_tx_replay #(.DEPTH(DEPTH)) u_replay (
        .clk     (clk),
        .wr_en   (take && state == S_XMIT && fetched < LEN_W'(DEPTH)),
        .wr_addr (fetched[AW-1:0]),
        .wr_data (in_data),
        .rd_addr (idx[AW-1:0]),
        .rd_data (rd_byte)
    );

    eth_tx_fcs u_fcs (
        .clk      (clk),
        .rst_n    (rst_n),
        .init     (start || col_hit),
        .upd      (load && (data_rem || pad_rem)),
        .din      (nb),
        .sel      (fcs_cnt[1:0]),
        .fcs_byte (fcs_byte)
    );
endmodule

// File: rtl/eth_tx_seq_chk.sv
module eth_tx_seq_chk
    import eth_tx_pkg::*;
#(
    parameter int RW      = 5,
    parameter int MAX_ATT = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tx_en,
    input logic          tx_d,
    input logic          col,
    input logic          done,
    input logic          stopped,
    input logic          in_ready,
    input logic          stop_req,
    input logic          st_late,
    input logic          st_excess,
    input logic [RW-1:0] st_retries,
    input tx_state_e     state
);
    p_quiet_line_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |-> !tx_d);

    p_col_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && col) |=> !tx_en);

    p_abort_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !(st_late && st_excess));

    p_excess_cnt_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && st_excess) |-> (st_retries == RW'(MAX_ATT)));

    p_idle_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && stop_req) |=> stopped);

    p_halt_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stopped |-> (!tx_en && !in_ready));

    p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

bind eth_tx_seq eth_tx_seq_chk #(.RW(RW), .MAX_ATT(MAX_ATT)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_en      (tx_en),
    .tx_d       (tx_d),
    .col        (col),
    .done       (done),
    .stopped    (stopped),
    .in_ready   (in_ready),
    .stop_req   (stop_req),
    .st_late    (st_late),
    .st_excess  (st_excess),
    .st_retries (st_retries),
    .state      (state)
);

// File: tb/sim_eth_tx_seq.sv
module sim_eth_tx_seq;
    localparam int CLK_PERIOD = 10;
    localparam int LEN_W = 11, DEPTH = 8, MIN_SEG = 9, MAX_ATT = 16;
    localparam int RW = $clog2(MAX_ATT + 1);

    logic clk = 0, rst_n = 0;
    logic in_valid = 0, in_last = 0, in_pad = 0, in_fcs = 0;
    logic [7:0] in_data = 0;
    logic [LEN_W-1:0] min_len = 0;
    logic col = 0, backoff_done = 0, stop_req = 0, restart_req = 0;
    logic in_ready, tx_en, tx_d, stopped, done, st_late, st_excess, st_short;
    logic [RW-1:0] st_retries;

    always #(CLK_PERIOD/2) clk = ~clk;

    eth_tx_seq #(.LEN_W(LEN_W), .DEPTH(DEPTH), .MIN_SEG(MIN_SEG), .MAX_ATT(MAX_ATT)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_last(in_last), .in_pad(in_pad), .in_fcs(in_fcs),
        .min_len(min_len), .col(col), .backoff_done(backoff_done),
        .stop_req(stop_req), .restart_req(restart_req), .tx_en(tx_en), .tx_d(tx_d),
        .stopped(stopped), .done(done), .st_retries(st_retries), .st_late(st_late),
        .st_excess(st_excess), .st_short(st_short));

    int n_chk = 0, n_err = 0;
    logic [7:0] frame_q[$];
    logic [7:0] exp_q[$];
    logic [7:0] cap[$];
    int plan[$];
    int got_done = 0;
    int last_retries = 0;
    logic last_late = 0, last_excess = 0, last_short = 0;
    logic [7:0] cur = 0;
    int nbit = 0, att_bits = 0, bo_cnt = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // reference check sequence: MSB-first CRC over bit-reversed input, reflected at end
    function automatic logic [31:0] ref_fcs();
        logic [31:0] r, o;
        logic fb;
        r = '1;
        foreach (exp_q[k]) begin
            for (int i = 0; i < 8; i++) begin
                fb = r[31] ^ exp_q[k][i];
                r = {r[30:0], 1'b0} ^ (fb ? 32'h04C1_1DB7 : 32'h0);
            end
        end
        for (int j = 0; j < 32; j++) o[j] = r[31-j];
        return ~o;
    endfunction

    function automatic void build_exp(input bit pad, input bit fcs, input int mlen);
        logic [31:0] f;
        exp_q = frame_q;
        if (pad) while (exp_q.size() < mlen) exp_q.push_back(8'h00);
        if (fcs) begin
            f = ref_fcs();
            for (int k = 0; k < 4; k++) exp_q.push_back(f[8*k +: 8]);
        end
    endfunction

    // line monitor, collision injector, backoff pulser
    always @(negedge clk) begin
        col = 1'b0;
        backoff_done = 1'b0;
        if (bo_cnt > 0) begin
            bo_cnt--;
            if (bo_cnt == 0) backoff_done = 1'b1;
        end
        if (tx_en) begin
            cur[nbit] = tx_d;
            nbit++;
            att_bits++;
            if (nbit == 8) begin
                cap.push_back(cur);
                nbit = 0;
            end
            if (plan.size() > 0 && att_bits == plan[0]) begin
                void'(plan.pop_front());
                col = 1'b1;
                cap.delete();
                nbit = 0;
                att_bits = 0;
                bo_cnt = 4;
            end
        end else if (nbit != 0) begin
            check(0, "R1", "tx_en fell inside a byte", nbit, 0);
            nbit = 0;
        end
        if (done) begin
            got_done++;
            last_retries = st_retries;
            last_late = st_late;
            last_excess = st_excess;
            last_short = st_short;
        end
    end

    task automatic drive();
        for (int i = 0; i < frame_q.size(); i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data = frame_q[i];
            in_last = (i == frame_q.size() - 1);
            while (!in_ready) @(negedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_last = 1'b0;
    endtask

    task automatic make_frame(input int len);
        frame_q.delete();
        for (int i = 0; i < len; i++) frame_q.push_back(8'($urandom));
    endtask

    task automatic run_frame(input bit pad, input bit fcs, input int mlen);
        int target;
        target = got_done + 1;
        in_pad = pad;
        in_fcs = fcs;
        min_len = LEN_W'(mlen);
        cap.delete();
        att_bits = 0;
        drive();
        while (got_done < target) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic cmp_stream(input string req);
        bit ok;
        ok = (cap.size() == exp_q.size());
        if (ok) foreach (exp_q[k]) if (cap[k] !== exp_q[k]) ok = 0;
        check(ok, req, "serial frame mismatch (size act/exp)", cap.size(), exp_q.size());
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        int len, ml, nc;
        bit pad, fcs;
        void'($urandom(32'h5EED_0001));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check(!tx_en && !in_ready && !stopped && !done, "R1",
              "reset state quiet", {tx_en, in_ready, stopped, done}, 0);

        // R3 R4 R8: short frame padded, check sequence appended
        make_frame(5);
        build_exp(1, 1, 12);
        run_frame(1, 1, 12);
        cmp_stream("R3");
        check(last_short == 1, "R8", "short flag on 5-byte frame", last_short, 1);

        // R8: short, no pad, no check sequence
        make_frame(6);
        build_exp(0, 0, 40);
        run_frame(0, 0, 40);
        cmp_stream("R4");
        check(last_short == 1, "R8", "short flag on 6-byte frame", last_short, 1);

        // R3: data longer than minimum gets no pad
        make_frame(15);
        build_exp(1, 1, 10);
        run_frame(1, 1, 10);
        cmp_stream("R3");
        check(last_short == 0, "R8", "no short flag on 15-byte frame", last_short, 0);

        // random frames, some with early collisions (R1 R2 R5 R12)
        for (int f = 0; f < 12; f++) begin
            len = 9 + int'($urandom % 14);
            pad = 1'($urandom);
            fcs = 1'($urandom);
            ml = 8 + int'($urandom % 24);
            nc = int'($urandom % 3);
            for (int c = 0; c < nc; c++) plan.push_back(1 + int'($urandom % 60));
            make_frame(len);
            build_exp(pad, fcs, ml);
            run_frame(pad, fcs, ml);
            cmp_stream(nc > 0 ? "R5" : "R1");
            check(last_retries == nc, "R12", "retry count", last_retries, nc);
            check(!last_late && !last_excess, "R2", "no abort flags",
                  {last_late, last_excess}, 0);
        end

        // R6: late collision after ten bytes
        make_frame(20);
        plan.push_back(83);
        run_frame(0, 1, 0);
        check(last_late == 1 && last_excess == 0, "R6", "late abort flags",
              {last_late, last_excess}, 2);
        check(cap.size() == 0, "R6", "bytes after late abort", cap.size(), 0);
        check(last_retries == 1, "R12", "late retry count", last_retries, 1);

        // R7: sixteen early collisions
        make_frame(12);
        for (int c = 0; c < MAX_ATT; c++) plan.push_back(5);
        run_frame(1, 1, 30);
        check(last_excess == 1 && last_late == 0, "R7", "excess abort flags",
              {last_late, last_excess}, 1);
        check(last_retries == MAX_ATT, "R7", "excess retry count", last_retries, MAX_ATT);
        check(cap.size() == 0, "R7", "bytes after excess abort", cap.size(), 0);

        // R11: restart while idle has no effect
        @(negedge clk); restart_req = 1;
        @(negedge clk); restart_req = 0;
        check(stopped == 0, "R11", "restart while idle", stopped, 0);

        // R9: stop while idle, then nothing goes out
        @(negedge clk); stop_req = 1;
        @(negedge clk); stop_req = 0;
        check(stopped == 1, "R9", "stopped after idle stop", stopped, 1);
        make_frame(10);
        in_valid = 1; in_data = frame_q[0];
        begin
            int busy = 0;
            repeat (20) begin
                @(negedge clk);
                if (tx_en || in_ready) busy++;
            end
            check(busy == 0 && stopped, "R9", "activity while halted", busy, 0);
        end
        restart_req = 1;
        @(negedge clk); restart_req = 0;
        check(stopped == 0, "R11", "restart leaves halt", stopped, 0);
        build_exp(0, 1, 0);
        run_frame(0, 1, 0);
        cmp_stream("R11");

        // R10: stop during a frame
        make_frame(14);
        build_exp(1, 1, 20);
        in_pad = 1; in_fcs = 1; min_len = 20; cap.delete(); att_bits = 0;
        begin
            int target, st_at_done;
            target = got_done + 1;
            st_at_done = -1;
            fork
                drive();
                begin
                    repeat (30) @(negedge clk);
                    stop_req = 1;
                    @(negedge clk);
                    stop_req = 0;
                end
            join
            while (got_done < target) begin
                @(negedge clk);
                if (done) st_at_done = stopped;
            end
            check(st_at_done == 1, "R10", "stopped with done pulse", st_at_done, 1);
        end
        cmp_stream("R10");
        @(negedge clk); restart_req = 1;
        @(negedge clk); restart_req = 0;
        check(stopped == 0, "R11", "restart after frame stop", stopped, 0);

        repeat (5) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule